// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block is a software-supervised watchdog built around one 32-bit register. A 15-bit counter advances once per timebase tick. A free-running prescaler divides the system clock to make that tick, and at the default ratio one tick is 10 ms. Software programs a 15-bit timeout value in the same register. When the counter reaches that value, the timer has expired. The counter then freezes and holds its value until software writes to the low half of the register. That write clears the count to zero, whatever data it carries.

An expiry status output is always available. A maskable interrupt output follows it. When the reset-enable bit is set, a registered, level-sensitive chip-reset request stays high for as long as the timer is expired. A timeout value of zero leaves the timer disarmed. Software kicks the watchdog by writing the count lanes before the match is reached.

The register port is a plain single-cycle access: an address, a write enable, four byte strobes, write data, and combinational read data. It has no handshake. Every access completes in the cycle it is presented.

Top module: `wdm_top`

## Requirements
- R1: The register answers only at address REG_ADDR, and any other address reads zero and ignores writes. It reads as {enable[31], timeout[30:16], 1'b0 at bit 15, count[14:0]}, so bit 15 always reads 0 and a 1 written there is dropped.
- R2: While the timeout is nonzero and the timer is not expired, the count rises by exactly one on each prescaler tick. One tick occurs every TICK_DIV clocks.
- R3: The expired output is high exactly when the timeout is nonzero and the count equals it.
- R4: While expired, the count holds its value on every tick until a clearing write.
- R5: A write with strobe bit 0 or bit 1 set clears the count to zero, whatever the data. If a tick falls in the same cycle, the clear wins.
- R6: Strobe bit 2 loads timeout[7:0] from data bits 23:16. Strobe bit 3 loads timeout[14:8] from data bits 30:24 and the enable from data bit 31. Without its strobe, a field keeps its value.
- R7: With a timeout of zero the count does not advance and expired stays low.
- R8: The interrupt output equals expired AND NOT mask, in the same cycle.
- R9: The reset request is registered: after each clock edge it equals (expired AND enable) as they stood before that edge. It is therefore never high while the enable was clear.
- R10: After reset the count, timeout and enable are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wr | input | 1 | Write enable, one cycle per write |
| reg_be | input | 4 | Byte strobes for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| expire_mask | input | 1 | Suppresses the interrupt output |
| expired | output | 1 | Count has matched a nonzero timeout |
| irq | output | 1 | Masked expiry indication |
| chip_rst_req | output | 1 | Registered whole-chip reset request |

## Verification
Two events can fall on the same clock edge: a clearing write to the count lanes and a prescaler tick. The bench tracks the tick phase from the number of edges since reset. It places kick writes exactly on tick edges, and the full sweep over timeout, enable, mask and start phase also lands writes at every offset. A collision is judged correct when the count reads zero after that edge and rises to one only at the following tick.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int CNT_W   = 15;
  localparam int REG_W   = 32;
  localparam int BE_W    = REG_W / 8;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic  en;
    cnt_t  timeout;
    logic  rsvd;
    cnt_t  count;
  } wdm_reg_t;
endpackage

// File: rtl/wdm_prescaler.sv
module wdm_prescaler #(
  parameter int DIV = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                 ph_q <= ph_q + 1'b1;
  end

  assign tick = (ph_q == LAST);
endmodule

// File: rtl/wdm_ctrl.sv
module wdm_ctrl
  import wdm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_hit,
  input  logic [1:0]     be_hi,
  input  logic [REG_W-1:0] wdata,
  output cnt_t           timeout,
  output logic           en
);
  localparam int LO_W = 8;
  localparam int HI_W = CNT_W - LO_W;

  logic [LO_W-1:0] to_lo_q;
  logic [HI_W-1:0] to_hi_q;
  logic            en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_lo_q <= '0;
    end else if (wr_hit && be_hi[0]) begin
      to_lo_q <= wdata[16 +: LO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_hi_q <= '0;
      en_q    <= 1'b0;
    end else if (wr_hit && be_hi[1]) begin
      to_hi_q <= wdata[24 +: HI_W];
      en_q    <= wdata[REG_W-1];
    end
  end

  assign timeout = {to_hi_q, to_lo_q};
  assign en      = en_q;
endmodule

// File: rtl/wdm_counter.sv
module wdm_counter
  import wdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  cnt_t timeout,
  output cnt_t count,
  output logic expired
);
  cnt_t cnt_q;
  logic armed;
  logic match;

  assign armed = (timeout != '0);
  assign match = armed && (cnt_q == timeout);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr)                    cnt_q <= '0;
    else if (tick && armed && !match) cnt_q <= cnt_q + 1'b1;
  end

  assign count   = cnt_q;
  assign expired = match;
endmodule

// File: rtl/wdm_top.sv
module wdm_top
  import wdm_pkg::*;
#(
  parameter int                TICK_DIV = 1000000,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              expire_mask,
  output logic              expired,
  output logic              irq,
  output logic              chip_rst_req
);
  logic     hit, wr_hit, clr, tick, en_w, exp_w, rst_q;
  cnt_t     cnt_w, to_w;
  wdm_reg_t view;

  assign hit    = (reg_addr == REG_ADDR);
  assign wr_hit = reg_wr && hit;
  assign clr    = wr_hit && (reg_be[0] || reg_be[1]);

  wdm_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  wdm_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .be_hi  (reg_be[3:2]),
    .wdata  (reg_wdata),
    .timeout(to_w),
    .en     (en_w)
  );

  wdm_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (clr),
    .timeout(to_w),
    .count  (cnt_w),
    .expired(exp_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= exp_w && en_w;
  end

  always_comb begin
    view.en      = en_w;
    view.timeout = to_w;
    view.rsvd    = 1'b0;
    view.count   = cnt_w;
  end

  assign reg_rdata    = hit ? view : '0;
  assign expired      = exp_w;
  assign irq          = exp_w && !expire_mask;
  assign chip_rst_req = rst_q;
endmodule

// File: rtl/wdm_checker.sv
module wdm_checker
  import wdm_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [3:0]        reg_be,
  input logic [31:0]       reg_rdata,
  input logic              expire_mask,
  input logic              expired,
  input logic              irq,
  input logic              chip_rst_req,
  input cnt_t              count,
  input cnt_t              timeout,
  input logic              en
);
  logic clr_any;
  assign clr_any = reg_wr && (reg_addr == REG_ADDR) && (reg_be[1:0] != 2'b00);

  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15] == 1'b0);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_any |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr_any) |=> $stable(count));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (count == '0));

  a_r7_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout == '0) |-> !expired);

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (expired && !expire_mask));

  a_r9_rst_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && en) |=> chip_rst_req);

  a_r9_rst_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !chip_rst_req);
endmodule

bind wdm_top wdm_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_be      (reg_be),
  .reg_rdata   (reg_rdata),
  .expire_mask (expire_mask),
  .expired     (expired),
  .irq         (irq),
  .chip_rst_req(chip_rst_req),
  .count       (cnt_w),
  .timeout     (to_w),
  .en          (en_w)
);

// File: tb/wdm_top_tb_top.sv
`timescale 1ns/1ps
module wdm_top_tb_top;
  localparam int         DIV  = 4;
  localparam logic [7:0] RADR = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = RADR;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        expire_mask = 1'b0;
  logic        expired, irq, chip_rst_req;

  int n_vec = 0;
  int n_bad = 0;
  int eidx  = -1;

  logic [14:0] m_cnt = '0;
  logic [14:0] m_to  = '0;
  logic        m_en  = 1'b0;
  logic        m_rst = 1'b0;

  always #5 clk = ~clk;

  wdm_top #(.TICK_DIV(DIV), .ADDR_W(8), .REG_ADDR(RADR)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .expire_mask(expire_mask), .expired(expired), .irq(irq),
    .chip_rst_req(chip_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: got %h expected %h", tag, eidx, got, exp);
    end
  endtask

  function automatic logic m_exp();
    return (m_to != '0) && (m_cnt == m_to);
  endfunction

  task automatic check_all();
    logic [31:0] rexp;
    rexp = (reg_addr == RADR) ? {m_en, m_to, 1'b0, m_cnt} : 32'h0;
    chk("R1 R2 R4 R5 R6 rdata", reg_rdata, rexp);
    chk("R3 R7 expired", {31'h0, expired}, {31'h0, m_exp()});
    chk("R8 irq", {31'h0, irq}, {31'h0, m_exp() && !expire_mask});
    chk("R9 chip_rst_req", {31'h0, chip_rst_req}, {31'h0, m_rst});
  endtask

  task automatic cyc();
    logic tk, hit, clr, oexp;
    @(posedge clk);
    eidx++;
    tk   = ((eidx % DIV) == DIV - 1);
    hit  = (reg_addr == RADR);
    clr  = reg_wr && hit && (reg_be[0] || reg_be[1]);
    oexp = m_exp();
    m_rst = oexp && m_en;
    if (clr) m_cnt = '0;
    else if (tk && m_to != '0 && !oexp) m_cnt = m_cnt + 1'b1;
    if (reg_wr && hit && reg_be[2]) m_to[7:0] = reg_wdata[23:16];
    if (reg_wr && hit && reg_be[3]) begin
      m_to[14:8] = reg_wdata[30:24];
      m_en       = reg_wdata[31];
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0; reg_be = 4'h0; reg_addr = RADR;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: run hung, got no end expected end");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    check_all();
    chk("R10 reset rdata", reg_rdata, 32'h0);
    rst_n = 1'b1;

    // R2 R3 R4 R8 R9: sweep timeout, enable, mask and start phase
    for (int s = 1; s <= 6; s++)
      for (int e = 0; e <= 1; e++)
        for (int m = 0; m <= 1; m++)
          for (int ph = 0; ph < DIV; ph++) begin
            expire_mask = m[0];
            idle(ph);
            // R1: bit 15 written as 1, junk in count lanes
            wr(RADR, 4'hF, {e[0], 15'(s), 1'b1, 15'h7FFF});
            idle(s * DIV + 6);
            // R5: clearing write through one low lane only
            wr(RADR, 4'h2, 32'h0000_5A5A);
            idle(3);
          end

    // R7: zero timeout never arms
    wr(RADR, 4'hF, {1'b1, 15'd0, 1'b0, 15'h0});
    idle(40);
    chk("R7 count held at zero", {17'h0, m_cnt}, 32'h0);

    // R6: partial timeout update unfreezes an expired count
    wr(RADR, 4'hF, {1'b1, 15'd3, 1'b0, 15'h0});
    idle(3 * DIV + 4);
    wr(RADR, 4'h4, {8'h00, 8'd5, 16'h0});
    idle(2 * DIV + 4);
    // R6: strobe 3 alone clears enable, low timeout byte kept
    wr(RADR, 4'h8, {1'b0, 7'h00, 8'hFF, 16'h0});
    idle(4);

    // R1: writes at another address are ignored
    wr(RADR + 8'h4, 4'hF, 32'hFFFF_FFFF);
    idle(2);
    reg_addr = RADR + 8'h8;
    cyc();
    reg_addr = RADR;

    // R5: clear collides with a tick edge
    wr(RADR, 4'hF, {1'b1, 15'd20, 1'b0, 15'h0});
    for (int k = 0; k < 4; k++) begin
      idle(DIV + 1);
      while (((eidx + 1) % DIV) != DIV - 1) cyc();
      wr(RADR, 4'h1, 32'hFFFF_FFFF);
      chk("R5 clear beats tick", {17'h0, m_cnt}, 32'h0);
    end
    idle(3 * DIV);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule